// File: doc/BRIEF.md
# Multi-Mode Position Counter Core

This block is the counting engine that sits behind an encoder front end. It accepts count strobes together with a direction bit from an upstream decoder, plus a validated index signal. It maintains a position counter, a preset/limit register, a snapshot register and a status byte. Two mode bytes select how counting behaves: free-running wrap, one-shot stop on overflow, clamping between zero and a limit, or division by a programmable modulus. They also select what an index event does and which events drive the two interrupt-style flags. The counter can be narrowed to 1, 2, 3 or 4 bytes, and overflow and underflow follow the narrowed width.

A host interface, which is not part of this block, writes the limit register, issues counter clear/load, snapshot and status clear strobes, and supplies the two mode bytes. All state changes happen on the rising clock edge. A command, an index action or a count step takes effect in the cycle after it is sampled.

Top module: `pos_counter_core`

## Requirements
- R1: After reset the counter, snapshot, limit register and sticky status bits are zero, the power-loss bit is 1, the direction bit is 0, and both flags are high. With `cnt_en_in`=1 the status byte reads 0x0C.
- R2: Free-running mode (`mode0[3:2]`=00): a step up from the all-ones value of the selected width gives 0 and sets carry (status bit 7). A step down from 0 gives all ones and sets borrow (status bit 6). Otherwise each step adds or subtracts 1.
- R3: Single-cycle mode (`mode0[3:2]`=01): after a step that produces carry or borrow, further steps are ignored until a counter clear, a counter load or an index load/clear.
- R4: Range-limit mode (`mode0[3:2]`=10): the count never rises above the limit register or falls below 0. It stays frozen at a bound and moves again as soon as a step in the opposite direction arrives.
- R5: Modulo-n mode (`mode0[3:2]`=11): a step up from n gives 0 with carry, and a step down from 0 gives n with borrow, where n is the limit register.
- R6: An index event is the transition of `idx_in` into its active level; `mode0[6]`=1 means active high and 0 means active low. `mode0[5:4]` selects the action: 00 none, 01 counter takes the limit register, 10 counter clears, 11 snapshot takes the counter. An enabled event sets status bit 4.
- R7: `cmd_clr_cntr` and `cmd_load_cntr` override a count step or index action in the same cycle. `cmd_load_otr` copies the counter into the snapshot. `cmd_clr_str` clears status bits 7..4 and the power-loss bit.
- R8: Steps are counted only while `cnt_en_in`=1 and `mode1[2]`=0. Status bit 3 shows that condition.
- R9: Status bit 1 holds the direction of the last counted step (1 = up). Status bit 0 is the top bit of the counter at the selected width.
- R10: `lflag_n` is low while any sticky status bit among carry, borrow, compare and index is set and enabled by `mode1[7]`, `mode1[6]`, `mode1[5]` or `mode1[4]` respectively. Once low, it stays low until the status is cleared.
- R11: `dflag_n` is a one-cycle low pulse in the cycle after the event. In free-running mode it fires on the enabled events. In single-cycle mode it fires on carry or borrow whatever the enables. In range-limit and modulo-n modes it fires on compare (count reaches the limit) during an up step, or on borrow.
- R12: `mode1[1:0]` = 00, 01, 10, 11 selects 4, 3, 2 or 1 bytes. Carry and borrow occur at that width, and the counter and limit compare use only those bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb | input | 1 | One count step request this cycle |
| cnt_up | input | 1 | Step direction, 1 = up |
| cnt_en_in | input | 1 | External count enable |
| idx_in | input | 1 | Validated index level |
| mode0 | input | 8 | Count mode [3:2], index action [5:4], index polarity [6] |
| mode1 | input | 8 | Byte width [1:0], count disable [2], flag enables [7:4] |
| dtr_wr | input | 1 | Write strobe for the limit register |
| dtr_wdata | input | 32 | Limit register write data |
| cmd_clr_cntr | input | 1 | Clear counter |
| cmd_load_cntr | input | 1 | Load counter from limit register |
| cmd_load_otr | input | 1 | Copy counter into snapshot |
| cmd_clr_str | input | 1 | Clear sticky status and power-loss bit |
| cnt_q | output | 32 | Counter value at selected width |
| otr_q | output | 32 | Snapshot register |
| status_q | output | 8 | Status byte |
| lflag_n | output | 1 | Latched active-low flag |
| dflag_n | output | 1 | Dynamic active-low flag pulse |

## Verification
The assertions check on every cycle that a range-limit count stays inside its bounds, that a modulo-n down step from zero lands on the limit, and that a halted single-cycle counter or a disabled counter holds its value. They also check that the latched flag stays low until a status clear and that a single-cycle overflow produces a dynamic pulse. The bench scenarios cover what needs a chosen history: wrap points at each byte width, each index action and polarity, the priority of host commands over steps, and the dynamic flag source selected in each mode.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int CNT_W  = 32;
  localparam int STAT_W = 8;
  localparam int EVT_N  = 4;

  typedef enum logic [1:0] {CM_FREE = 2'b00, CM_SINGLE = 2'b01,
                            CM_RANGE = 2'b10, CM_MODN = 2'b11} cmode_e;
  typedef enum logic [1:0] {IX_OFF = 2'b00, IX_LOAD = 2'b01,
                            IX_CLEAR = 2'b10, IX_LATCH = 2'b11} ixact_e;

  typedef struct packed {
    logic [CNT_W-1:0] nxt;
    logic             cy;
    logic             bw;
    logic             cmp;
  } step_t;

  // Mask of active bits for a byte-width selector (00 = 4 bytes ... 11 = 1 byte)
  function automatic logic [CNT_W-1:0] width_mask(input logic [1:0] sel);
    logic [CNT_W:0] one_past;
    one_past = '0;
    one_past[8 * (4 - int'(sel))] = 1'b1;
    return CNT_W'(one_past - 1'b1);
  endfunction

  function automatic logic top_bit(input logic [CNT_W-1:0] v, input logic [1:0] sel);
    return v[8 * (4 - int'(sel)) - 1];
  endfunction

  // One step of the counter in the given mode
  function automatic step_t next_count(input logic [CNT_W-1:0] cur,
                                       input logic [CNT_W-1:0] lim,
                                       input logic [CNT_W-1:0] msk,
                                       input logic up, input cmode_e cm);
    step_t s;
    s = '0;
    s.nxt = cur;
    if (up) begin
      if ((cm == CM_RANGE) && (cur == lim)) s.cy = 1'b1;
      else if ((cm == CM_MODN) && (cur == lim)) begin
        s.nxt = '0; s.cy = 1'b1;
      end else if (cur == msk) begin
        s.nxt = '0; s.cy = 1'b1;
      end else s.nxt = cur + 1'b1;
    end else begin
      if (cur == '0) begin
        s.bw = 1'b1;
        if (cm == CM_MODN) s.nxt = lim;
        else if (cm != CM_RANGE) s.nxt = msk;
      end else s.nxt = cur - 1'b1;
    end
    s.cmp = (s.nxt == lim);
    return s;
  endfunction
endpackage

// File: rtl/pcc_step.sv
module pcc_step
  import pcc_pkg::*;
(
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] lim,
  input  logic [1:0]       wsel,
  input  logic             up,
  input  cmode_e           cm,
  output logic [CNT_W-1:0] nxt,
  output logic             cy,
  output logic             bw,
  output logic             cmp
);
  step_t s;
  always_comb begin
    s   = next_count(cur, lim, width_mask(wsel), up, cm);
    nxt = s.nxt;
    cy  = s.cy;
    bw  = s.bw;
    cmp = s.cmp;
  end
endmodule

// File: rtl/pcc_flags.sv
module pcc_flags
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cmode_e           cm,
  input  logic [EVT_N-1:0] evt,      // {carry, borrow, compare, index}
  input  logic             up_step,
  input  logic [EVT_N-1:0] fen,
  input  logic             clr_str,
  output logic [EVT_N-1:0] sticky,
  output logic             pls,
  output logic             lflag_n,
  output logic             dflag_n
);
  logic dyn_hit;

  always_comb begin
    unique case (cm)
      CM_FREE:   dyn_hit = |(evt & fen);
      CM_SINGLE: dyn_hit = evt[3] | evt[2];
      default:   dyn_hit = (evt[1] & up_step) | evt[2];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky  <= '0;
      pls     <= 1'b1;
      dflag_n <= 1'b1;
    end else begin
      dflag_n <= ~dyn_hit;
      if (clr_str) begin
        sticky <= evt;
        pls    <= 1'b0;
      end else begin
        sticky <= sticky | evt;
      end
    end
  end

  assign lflag_n = ~|(sticky & fen);

  AST_LFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lflag_n && !clr_str) |=> (!lflag_n || (fen != $past(fen)))); // R10
  AST_SINGLE_DYN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm == CM_SINGLE) && (evt[3] || evt[2])) |=> !dflag_n); // R11
  AST_PLS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_str |=> !pls); // R7
endmodule

// File: rtl/pos_counter_core.sv
module pos_counter_core
  import pcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_stb,
  input  logic              cnt_up,
  input  logic              cnt_en_in,
  input  logic              idx_in,
  input  logic [7:0]        mode0,
  input  logic [7:0]        mode1,
  input  logic              dtr_wr,
  input  logic [CNT_W-1:0]  dtr_wdata,
  input  logic              cmd_clr_cntr,
  input  logic              cmd_load_cntr,
  input  logic              cmd_load_otr,
  input  logic              cmd_clr_str,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  otr_q,
  output logic [STAT_W-1:0] status_q,
  output logic              lflag_n,
  output logic              dflag_n
);
  cmode_e           cm;
  ixact_e           ixa;
  logic             ipol, cen, halted, halt_eff, dir_r, idx_prev, idx_act, idx_evt;
  logic             host_ld, idx_ld, step_go, pls;
  logic [1:0]       wsel;
  logic [EVT_N-1:0] fen, evt, sticky;
  logic [CNT_W-1:0] cnt_r, otr_r, dtr_r, msk, cur, dtr_m, s_nxt;
  logic             s_cy, s_bw, s_cmp;
  logic             unused_cfg;

  assign cm         = cmode_e'(mode0[3:2]);
  assign ixa        = ixact_e'(mode0[5:4]);
  assign ipol       = mode0[6];
  assign wsel       = mode1[1:0];
  assign fen        = mode1[7:4];
  assign unused_cfg = ^{mode0[1:0], mode1[3]};

  assign msk      = width_mask(wsel);
  assign cur      = cnt_r & msk;
  assign dtr_m    = dtr_r & msk;
  assign cen      = cnt_en_in & ~mode1[2];
  assign halt_eff = halted & (cm == CM_SINGLE);

  // index: transition into the active level
  assign idx_act = (idx_in == ipol);
  assign idx_evt = idx_act & ~idx_prev & (ixa != IX_OFF);
  assign idx_ld  = idx_evt & ((ixa == IX_LOAD) | (ixa == IX_CLEAR));
  assign host_ld = cmd_clr_cntr | cmd_load_cntr;
  assign step_go = cnt_stb & cen & ~halt_eff & ~host_ld & ~idx_ld;

  pcc_step u_step (
    .cur (cur), .lim (dtr_m), .wsel (wsel), .up (cnt_up), .cm (cm),
    .nxt (s_nxt), .cy (s_cy), .bw (s_bw), .cmp (s_cmp)
  );

  assign evt = {step_go & s_cy, step_go & s_bw, step_go & s_cmp, idx_evt};

  pcc_flags u_flags (
    .clk (clk), .rst_n (rst_n), .cm (cm), .evt (evt),
    .up_step (step_go & cnt_up), .fen (fen), .clr_str (cmd_clr_str),
    .sticky (sticky), .pls (pls), .lflag_n (lflag_n), .dflag_n (dflag_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r    <= '0;
      otr_r    <= '0;
      dtr_r    <= '0;
      halted   <= 1'b0;
      dir_r    <= 1'b0;
      idx_prev <= 1'b0;
    end else begin
      idx_prev <= idx_act;
      if (dtr_wr) dtr_r <= dtr_wdata;
      if (cmd_clr_cntr) begin
        cnt_r <= '0; halted <= 1'b0;
      end else if (cmd_load_cntr) begin
        cnt_r <= dtr_m; halted <= 1'b0;
      end else if (idx_ld) begin
        cnt_r  <= (ixa == IX_LOAD) ? dtr_m : '0;
        halted <= 1'b0;
      end else if (step_go) begin
        cnt_r <= s_nxt;
        dir_r <= cnt_up;
        if ((cm == CM_SINGLE) && (s_cy || s_bw)) halted <= 1'b1;
      end
      if (cmd_load_otr || (idx_evt && (ixa == IX_LATCH))) otr_r <= cur;
    end
  end

  assign cnt_q    = cur;
  assign otr_q    = otr_r;
  assign status_q = {sticky, cen, pls, dir_r, top_bit(cur, wsel)};

  AST_RANGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm == CM_RANGE) && step_go && (cur <= dtr_m)) |=> (cnt_r <= $past(dtr_m))); // R4
  AST_MODN_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm == CM_MODN) && step_go && !cnt_up && (cur == '0)) |=> (cnt_r == $past(dtr_m))); // R5
  AST_SINGLE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_eff && !host_ld && !idx_ld) |=> (cnt_r == $past(cnt_r))); // R3
  AST_COUNT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !host_ld && !idx_ld) |=> (cnt_r == $past(cnt_r))); // R8
endmodule

// File: tb/pos_counter_core_test.sv
module pos_counter_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_stb = 1'b0, cnt_up = 1'b0, cnt_en_in = 1'b1, idx_in = 1'b1;
  logic [7:0]  mode0 = 8'h00, mode1 = 8'h00;
  logic        dtr_wr = 1'b0;
  logic [31:0] dtr_wdata = '0;
  logic        cmd_clr_cntr = 1'b0, cmd_load_cntr = 1'b0, cmd_load_otr = 1'b0, cmd_clr_str = 1'b0;
  logic [31:0] cnt_q, otr_q;
  logic [7:0]  status_q;
  logic        lflag_n, dflag_n;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pos_counter_core uut (
    .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .cnt_up(cnt_up), .cnt_en_in(cnt_en_in),
    .idx_in(idx_in), .mode0(mode0), .mode1(mode1), .dtr_wr(dtr_wr), .dtr_wdata(dtr_wdata),
    .cmd_clr_cntr(cmd_clr_cntr), .cmd_load_cntr(cmd_load_cntr), .cmd_load_otr(cmd_load_otr),
    .cmd_clr_str(cmd_clr_str), .cnt_q(cnt_q), .otr_q(otr_q), .status_q(status_q),
    .lflag_n(lflag_n), .dflag_n(dflag_n)
  );

  // {up, expected count} at 1-byte width, free-running, start 0xFE
  localparam logic [8:0] VEC [12] = '{9'h1FF, 9'h100, 9'h0FF, 9'h0FE, 9'h1FF, 9'h100,
                                      9'h101, 9'h000, 9'h0FF, 9'h100, 9'h101, 9'h102};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic step(input logic up);
    cnt_stb = 1'b1; cnt_up = up; tick(); cnt_stb = 1'b0;
  endtask

  task automatic write_dtr(input logic [31:0] v);
    dtr_wr = 1'b1; dtr_wdata = v; tick(); dtr_wr = 1'b0;
  endtask

  task automatic load_cnt();
    cmd_load_cntr = 1'b1; tick(); cmd_load_cntr = 1'b0;
  endtask

  task automatic clr_cnt();
    cmd_clr_cntr = 1'b1; tick(); cmd_clr_cntr = 1'b0;
  endtask

  task automatic clr_str();
    cmd_clr_str = 1'b1; tick(); cmd_clr_str = 1'b0;
  endtask

  task automatic idx_pulse(input logic active);
    idx_in = active; tick(); idx_in = ~active; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R1 count", cnt_q, 0);
    chk("R1 snapshot", otr_q, 0);
    chk("R1 status", {24'h0, status_q}, 32'h0C);
    chk("R1 lflag", {31'h0, lflag_n}, 1);
    chk("R1 dflag", {31'h0, dflag_n}, 1);

    // R2 vector walk at one byte
    mode1 = 8'h03;
    write_dtr(32'hFE); load_cnt();
    chk("R12 load masked", cnt_q, 32'hFE);
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][8]);
      chk("R2 walk", cnt_q, {24'h0, VEC[i][7:0]});
    end
    chk("R2 carry+borrow latched", {30'h0, status_q[7:6]}, 2'b11);
    chk("R10 lflag masked off", {31'h0, lflag_n}, 1);
    clr_str();
    chk("R7 status clear", {24'h0, status_q}, 32'h0A);

    // R12 other widths
    mode1 = 8'h02; write_dtr(32'hFFFF); load_cnt(); step(1'b1);
    chk("R12 two-byte carry wrap", cnt_q, 0);
    chk("R12 two-byte carry bit", {31'h0, status_q[7]}, 1);
    mode1 = 8'h00; clr_str(); step(1'b0);
    chk("R12 four-byte borrow wrap", cnt_q, 32'hFFFFFFFF);
    chk("R12 four-byte borrow bit", {31'h0, status_q[6]}, 1);

    // R10/R11 free-running flags, carry enabled only
    mode1 = 8'h80; clr_str(); write_dtr(32'hFFFFFFFF); load_cnt();
    step(1'b1);
    chk("R11 free dyn on carry", {31'h0, dflag_n}, 0);
    chk("R10 latched on carry", {31'h0, lflag_n}, 0);
    tick();
    chk("R11 dyn one cycle", {31'h0, dflag_n}, 1);
    chk("R10 latched holds", {31'h0, lflag_n}, 0);
    step(1'b0);
    chk("R11 free borrow not enabled", {31'h0, dflag_n}, 1);
    clr_str();
    chk("R10 latched released", {31'h0, lflag_n}, 1);

    // R3 single-cycle
    mode0 = 8'h04; mode1 = 8'h03;
    write_dtr(32'hFF); load_cnt();
    step(1'b1);
    chk("R3 wrap", cnt_q, 0);
    chk("R11 single dyn on carry", {31'h0, dflag_n}, 0);
    step(1'b1);
    chk("R3 halted up", cnt_q, 0);
    step(1'b0);
    chk("R3 halted down", cnt_q, 0);
    load_cnt(); step(1'b0);
    chk("R3 resumes after load", cnt_q, 32'hFE);

    // R4 range-limit
    mode0 = 8'h08; mode1 = 8'h00;
    write_dtr(3); clr_cnt();
    step(1'b1); step(1'b1); step(1'b1);
    chk("R4 reach limit", cnt_q, 3);
    chk("R11 range dyn on compare up", {31'h0, dflag_n}, 0);
    step(1'b1);
    chk("R4 frozen at top", cnt_q, 3);
    step(1'b0);
    chk("R4 resumes down", cnt_q, 2);
    step(1'b0); step(1'b0); step(1'b0);
    chk("R4 frozen at zero", cnt_q, 0);
    chk("R11 range dyn on borrow", {31'h0, dflag_n}, 0);
    step(1'b1);
    chk("R4 resumes up", cnt_q, 1);

    // R5 modulo-n
    mode0 = 8'h0C; write_dtr(4); clr_cnt();
    step(1'b0);
    chk("R5 down wraps to n", cnt_q, 4);
    chk("R11 modn dyn on borrow", {31'h0, dflag_n}, 0);
    step(1'b1);
    chk("R5 up wraps to zero", cnt_q, 0);
    step(1'b1); step(1'b1); step(1'b1); step(1'b1);
    chk("R5 reach n", cnt_q, 4);
    chk("R11 modn dyn on compare up", {31'h0, dflag_n}, 0);
    step(1'b1);
    chk("R5 wrap again", cnt_q, 0);

    // R6 index actions
    idx_in = 1'b0; mode0 = 8'h50; clr_str(); write_dtr(32'h55);
    idx_pulse(1'b1);
    chk("R6 index load", cnt_q, 32'h55);
    chk("R6 index status bit", {31'h0, status_q[4]}, 1);
    mode0 = 8'h60; idx_pulse(1'b1);
    chk("R6 index clear", cnt_q, 0);
    step(1'b1); step(1'b1); step(1'b1);
    mode0 = 8'h70; idx_pulse(1'b1);
    chk("R6 index latch snapshot", otr_q, 3);
    chk("R6 index latch keeps count", cnt_q, 3);
    mode0 = 8'h40; step(1'b1); idx_pulse(1'b1);
    chk("R6 index off count", cnt_q, 4);
    chk("R6 index off snapshot", otr_q, 3);
    idx_in = 1'b1; mode0 = 8'h20; tick();
    idx_pulse(1'b0);
    chk("R6 active-low clear", cnt_q, 0);

    // R8 count gating
    mode0 = 8'h00; cnt_en_in = 1'b0; step(1'b1);
    chk("R8 ext disable", cnt_q, 0);
    chk("R8 status enable bit", {31'h0, status_q[3]}, 0);
    cnt_en_in = 1'b1; mode1 = 8'h04; step(1'b1);
    chk("R8 mode disable", cnt_q, 0);
    chk("R8 status enable bit mode", {31'h0, status_q[3]}, 0);
    mode1 = 8'h00; step(1'b1);
    chk("R8 enabled counts", cnt_q, 1);

    // R7 command priority and snapshot
    cnt_stb = 1'b1; cnt_up = 1'b1; cmd_clr_cntr = 1'b1; tick();
    cnt_stb = 1'b0; cmd_clr_cntr = 1'b0;
    chk("R7 clear beats step", cnt_q, 0);
    step(1'b1); step(1'b1);
    cmd_load_otr = 1'b1; tick(); cmd_load_otr = 1'b0;
    chk("R7 snapshot command", otr_q, 2);

    // R9 sign and direction
    mode1 = 8'h03; write_dtr(32'h80); load_cnt();
    chk("R9 sign at byte width", {31'h0, status_q[0]}, 1);
    step(1'b0);
    chk("R9 sign clear", {31'h0, status_q[0]}, 0);
    chk("R9 direction down", {31'h0, status_q[1]}, 0);
    step(1'b1);
    chk("R9 direction up", {31'h0, status_q[1]}, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule